// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register and arithmetic half of a simple processor. All moves between its registers go over one shared internal bus. Each register has an input enable that loads it from the bus and an output enable that puts it on the bus. The registers are the program counter, the memory address register, the memory data register, the instruction register, a scratch register and four general registers. An adder/logic unit has no storage of its own. Its A operand is either the Y latch or the constant 4, and its B operand is the bus. Its result can only be kept by loading it into the Z latch, and Z later drives the bus.

An external sequencer supplies one bundle of control strobes per clock and holds it for the whole cycle. Instruction decode and step sequencing are outside this block. Because of the single bus and the two latches, a register-to-register add takes three steps. First the first operand goes into Y. Then the second operand goes on the bus while the result is captured in Z. Finally Z is moved to the destination. The memory address register drives the memory address lines at all times. The memory data register can also load from, and drive, the memory data lines.

Top module: `spb_datapath`

## Requirements
- R1: While rst_ni is low, every register (pc, mar, mdr, ir, tmp, Y, Z, all general registers) is cleared to zero asynchronously.
- R2: A register whose input enable is high at a rising clock edge takes the bus value. A register whose input enable is low keeps its value, whatever is on the bus.
- R3: The bus, which is also visible on bus_o, equals the one register whose output enable is high. With no output enable high it reads zero. At most one output enable may be high in a cycle.
- R4: ALU operand A is the constant 4 when sel_const_i is high, otherwise the Y register. Operand B is always the bus.
- R5: alu_op_i encodes 0 = A+B+carry, 1 = A+~B+carry (subtract when carry_i is 1), 2 = A AND B, 3 = A OR B, 4 = pass B. Every other code gives zero. Arithmetic wraps modulo 2^DW.
- R6: Z loads the ALU result only at an edge where z_in_i is high and holds otherwise. With z_out_i high, Z drives the bus.
- R7: mem_addr_o always shows the MAR. After an edge with mar_in_i high, it equals the bus value of that cycle.
- R8: With mdr_mem_in_i high, the MDR loads mem_rdata_i, which takes priority over its bus-side load mdr_in_i. With mdr_mem_out_i high, mem_wdata_o shows the MDR and mem_wr_o is high. Otherwise both are zero.
- R9: Three steps load the sum of Ra and Rb into Rd: (Ra out, Y in), (Rb out, A=Y, add, Z in), (Z out, Rd in).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_in_i | input | 1 | Load program counter from bus |
| pc_out_i | input | 1 | Drive program counter on bus |
| mar_in_i | input | 1 | Load memory address register from bus |
| mdr_in_i | input | 1 | Load MDR from bus |
| mdr_out_i | input | 1 | Drive MDR on bus |
| mdr_mem_in_i | input | 1 | Load MDR from memory data lines |
| mdr_mem_out_i | input | 1 | Drive MDR on memory data lines |
| ir_in_i | input | 1 | Load instruction register from bus |
| ir_out_i | input | 1 | Drive instruction register on bus |
| tmp_in_i | input | 1 | Load scratch register from bus |
| tmp_out_i | input | 1 | Drive scratch register on bus |
| gpr_in_i | input | NGPR | Per-general-register load enables |
| gpr_out_i | input | NGPR | Per-general-register bus drive enables |
| y_in_i | input | 1 | Load Y from bus |
| sel_const_i | input | 1 | ALU A operand: 1 = constant 4, 0 = Y |
| alu_op_i | input | 3 | ALU operation code |
| carry_i | input | 1 | ALU carry in |
| z_in_i | input | 1 | Load Z from ALU result |
| z_out_i | input | 1 | Drive Z on bus |
| mem_rdata_i | input | DW | Memory read data |
| mem_addr_o | output | DW | Memory address (MAR) |
| mem_wdata_o | output | DW | Memory write data (MDR when driven) |
| mem_wr_o | output | 1 | MDR drives memory data lines |
| bus_o | output | DW | Internal bus value |

## Verification
Every cycle, the assertions check that at most one bus driver is enabled and that an undriven bus reads zero. They also check that every register holds when it is not loaded, that the MAR follows the bus after a load, and that a memory-side MDR load captures the read data. The bench scenarios are needed to show that the ALU codes, carry handling and constant-4 path give the right values. The same goes for the three-step add sequence, memory-side priority over a bus-side MDR load, and the write-data gating, all observed through the bus and memory ports.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_PASS = 3'd4
  } alu_op_e;
endpackage

// File: rtl/spb_reg.sv
module spb_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  a_r2_hold_unloaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/spb_bus_mux.sv
module spb_bus_mux #(
  parameter int DW   = 32,
  parameter int NSRC = 9
) (
  input  logic [NSRC-1:0]         oe_i,
  input  logic [NSRC-1:0][DW-1:0] src_i,
  output logic [DW-1:0]           bus_o
);
  // AND-OR mux: idle bus is zero
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < NSRC; i++)
      bus_o = bus_o | (src_i[i] & {DW{oe_i[i]}});
  end
endmodule

// File: rtl/spb_alu.sv
module spb_alu
  import spb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] cin_ext;
  assign cin_ext = {{(DW-1){1'b0}}, cin_i};

  always_comb begin
    unique case (op_i)
      ALU_ADD:  res_o = a_i + b_i + cin_ext;
      ALU_SUB:  res_o = a_i + ~b_i + cin_ext;
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_PASS: res_o = b_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/spb_datapath.sv
module spb_datapath
  import spb_pkg::*;
#(
  parameter int DW        = 32,
  parameter int NGPR      = 4,
  parameter int INC_CONST = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pc_in_i,
  input  logic            pc_out_i,
  input  logic            mar_in_i,
  input  logic            mdr_in_i,
  input  logic            mdr_out_i,
  input  logic            mdr_mem_in_i,
  input  logic            mdr_mem_out_i,
  input  logic            ir_in_i,
  input  logic            ir_out_i,
  input  logic            tmp_in_i,
  input  logic            tmp_out_i,
  input  logic [NGPR-1:0] gpr_in_i,
  input  logic [NGPR-1:0] gpr_out_i,
  input  logic            y_in_i,
  input  logic            sel_const_i,
  input  logic [2:0]      alu_op_i,
  input  logic            carry_i,
  input  logic            z_in_i,
  input  logic            z_out_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_wr_o,
  output logic [DW-1:0]   bus_o
);
  localparam int NFIX = 5;            // pc, mdr, ir, tmp, z
  localparam int NSRC = NFIX + NGPR;
  localparam int S_PC = 0, S_MDR = 1, S_IR = 2, S_TMP = 3, S_Z = 4;

  logic [NSRC-1:0]         oe;
  logic [NSRC-1:0][DW-1:0] src;
  logic [DW-1:0] bus, pc_q, mar_q, mdr_q, ir_q, tmp_q, y_q, z_q;
  logic [DW-1:0] mdr_d, alu_a, alu_res;
  logic          mdr_ld;

  assign oe[S_PC]  = pc_out_i;
  assign oe[S_MDR] = mdr_out_i;
  assign oe[S_IR]  = ir_out_i;
  assign oe[S_TMP] = tmp_out_i;
  assign oe[S_Z]   = z_out_i;
  assign src[S_PC]  = pc_q;
  assign src[S_MDR] = mdr_q;
  assign src[S_IR]  = ir_q;
  assign src[S_TMP] = tmp_q;
  assign src[S_Z]   = z_q;

  spb_bus_mux #(.DW(DW), .NSRC(NSRC)) i_bus (.oe_i(oe), .src_i(src), .bus_o(bus));

  spb_reg #(.DW(DW)) i_pc  (.clk_i, .rst_ni, .ld_i(pc_in_i),  .d_i(bus), .q_o(pc_q));
  spb_reg #(.DW(DW)) i_mar (.clk_i, .rst_ni, .ld_i(mar_in_i), .d_i(bus), .q_o(mar_q));
  spb_reg #(.DW(DW)) i_ir  (.clk_i, .rst_ni, .ld_i(ir_in_i),  .d_i(bus), .q_o(ir_q));
  spb_reg #(.DW(DW)) i_tmp (.clk_i, .rst_ni, .ld_i(tmp_in_i), .d_i(bus), .q_o(tmp_q));
  spb_reg #(.DW(DW)) i_y   (.clk_i, .rst_ni, .ld_i(y_in_i),   .d_i(bus), .q_o(y_q));

  // memory side wins over bus side
  assign mdr_ld = mdr_mem_in_i | mdr_in_i;
  assign mdr_d  = mdr_mem_in_i ? mem_rdata_i : bus;
  spb_reg #(.DW(DW)) i_mdr (.clk_i, .rst_ni, .ld_i(mdr_ld), .d_i(mdr_d), .q_o(mdr_q));

  for (genvar g = 0; g < NGPR; g++) begin : g_gpr
    logic [DW-1:0] q;
    spb_reg #(.DW(DW)) i_r (.clk_i, .rst_ni, .ld_i(gpr_in_i[g]), .d_i(bus), .q_o(q));
    assign oe[NFIX+g]  = gpr_out_i[g];
    assign src[NFIX+g] = q;
  end

  assign alu_a = sel_const_i ? DW'(INC_CONST) : y_q;
  spb_alu #(.DW(DW)) i_alu (
    .a_i(alu_a), .b_i(bus), .op_i(alu_op_e'(alu_op_i)), .cin_i(carry_i), .res_o(alu_res)
  );
  spb_reg #(.DW(DW)) i_z (.clk_i, .rst_ni, .ld_i(z_in_i), .d_i(alu_res), .q_o(z_q));

  assign bus_o       = bus;
  assign mem_addr_o  = mar_q;
  assign mem_wr_o    = mdr_mem_out_i;
  assign mem_wdata_o = mdr_mem_out_i ? mdr_q : '0;

  a_r3_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oe) <= 1);
  a_r3_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe == '0) |-> (bus_o == '0));
  a_r7_mar_follows_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mar_in_i |=> (mem_addr_o == $past(bus_o)));
  a_r8_mdr_mem_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdr_mem_in_i |=> (mdr_q == $past(mem_rdata_i)));
endmodule

// File: tb/test_spb_datapath.sv
module test_spb_datapath;
  localparam int DW = 32;
  localparam int NG = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pc_in_i, pc_out_i, mar_in_i, mdr_in_i, mdr_out_i, mdr_mem_in_i, mdr_mem_out_i;
  logic ir_in_i, ir_out_i, tmp_in_i, tmp_out_i, y_in_i, sel_const_i, carry_i, z_in_i, z_out_i;
  logic [NG-1:0] gpr_in_i, gpr_out_i;
  logic [2:0] alu_op_i;
  logic [DW-1:0] mem_rdata_i, mem_addr_o, mem_wdata_o, bus_o;
  logic mem_wr_o;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] mdl [9];   // 0 pc,1 mdr,2 ir,3 tmp,4 z,5..8 gpr
  logic [DW-1:0] ymdl;

  always #2 clk_i = ~clk_i;

  spb_datapath #(.DW(DW), .NGPR(NG)) i_spb_datapath (.*);

  function automatic logic [DW-1:0] alu_ref(logic [DW-1:0] a, b, logic [2:0] op, logic c);
    case (op)
      3'd0: return a + b + DW'(c);
      3'd1: return a + ~b + DW'(c);
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return b;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    {pc_in_i, pc_out_i, mar_in_i, mdr_in_i, mdr_out_i, mdr_mem_in_i, mdr_mem_out_i} = '0;
    {ir_in_i, ir_out_i, tmp_in_i, tmp_out_i, y_in_i, sel_const_i, carry_i, z_in_i, z_out_i} = '0;
    gpr_in_i = '0; gpr_out_i = '0; alu_op_i = '0; mem_rdata_i = '0;
  endtask

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i); clr();
  endtask

  task automatic set_out(int s);
    case (s)
      0: pc_out_i = 1; 1: mdr_out_i = 1; 2: ir_out_i = 1; 3: tmp_out_i = 1; 4: z_out_i = 1;
      default: gpr_out_i[s-5] = 1;
    endcase
  endtask

  task automatic set_in(int s);
    case (s)
      0: pc_in_i = 1; 1: mdr_in_i = 1; 2: ir_in_i = 1; 3: tmp_in_i = 1;
      default: gpr_in_i[s-5] = 1;
    endcase
  endtask

  task automatic rd(int s, string tag);
    set_out(s); #1 chk(tag, bus_o, mdl[s]); cyc();
  endtask

  task automatic ld(int s, logic [DW-1:0] v);
    mdr_mem_in_i = 1; mem_rdata_i = v; cyc(); mdl[1] = v;
    if (s != 1) begin mdr_out_i = 1; set_in(s); cyc(); mdl[s] = v; end
  endtask

  // three-step operation; dst result checked by reading it back
  task automatic alu3(int a, int b, int dst, logic [2:0] op, logic c, logic k, string tag);
    logic [DW-1:0] av, zexp;
    if (!k) begin set_out(a); y_in_i = 1; cyc(); ymdl = mdl[a]; end
    av = k ? DW'(4) : ymdl;
    set_out(b); sel_const_i = k; alu_op_i = op; carry_i = c; z_in_i = 1; cyc();
    zexp = alu_ref(av, mdl[b], op, c); mdl[4] = zexp;
    z_out_i = 1; set_in(dst); #1 chk({tag, " R6 z on bus"}, bus_o, zexp); cyc();
    mdl[dst] = zexp;
    rd(dst, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    clr();
    for (int i = 0; i < 9; i++) mdl[i] = '0;
    ymdl = '0;
    repeat (2) @(negedge clk_i);
    // R1 reset values, R3 idle bus
    #1 chk("R3 idle bus zero", bus_o, '0);
    chk("R1 mar reset", mem_addr_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int s = 0; s < 9; s++) rd(s, "R1 reset value");
    // R9 textbook sequence R1+R2 -> R3 (gpr 5+1, 5+2 -> 5+3)
    ld(6, 32'h0000_1111); ld(7, 32'h0000_2222);
    alu3(6, 7, 8, 3'd0, 1'b0, 1'b0, "R9 add seq");
    chk("R9 sum value", mdl[8], 32'h0000_3333);
    // R2 hold: gpr5 not loaded while other values pass the bus
    ld(5, 32'hA5A5_0001);
    set_out(6); tmp_in_i = 1; cyc(); mdl[3] = mdl[6];
    rd(5, "R2 hold unloaded");
    rd(3, "R2 tmp loaded");
    ld(2, 32'hDEAD_BEEF); rd(2, "R2 ir load");
    // R4 constant path: pc + 4, and wrap
    ld(0, 32'h0000_0100);
    alu3(0, 0, 0, 3'd0, 1'b0, 1'b1, "R4 pc plus const");
    chk("R4 pc value", mdl[0], 32'h0000_0104);
    ld(5, 32'hFFFF_FFFE);
    alu3(0, 5, 5, 3'd0, 1'b0, 1'b1, "R4 R5 wrap");
    chk("R5 wrap value", mdl[5], 32'h0000_0002);
    // R5 op codes
    ld(5, 32'h0000_0010); ld(6, 32'h0000_0003);
    alu3(5, 6, 7, 3'd1, 1'b1, 1'b0, "R5 sub");
    chk("R5 sub value", mdl[7], 32'h0000_000D);
    alu3(6, 5, 7, 3'd1, 1'b1, 1'b0, "R5 sub negative");
    alu3(5, 6, 7, 3'd0, 1'b1, 1'b0, "R5 add carry");
    alu3(5, 6, 7, 3'd2, 1'b0, 1'b0, "R5 and");
    alu3(5, 6, 7, 3'd3, 1'b0, 1'b0, "R5 or");
    alu3(5, 6, 7, 3'd4, 1'b0, 1'b0, "R5 pass");
    alu3(5, 6, 7, 3'd5, 1'b0, 1'b0, "R5 undefined code");
    alu3(5, 6, 7, 3'd7, 1'b1, 1'b0, "R5 undefined code7");
    // R6 z holds without z_in
    alu3(5, 6, 8, 3'd0, 1'b0, 1'b0, "R6 prep");
    set_out(7); alu_op_i = 3'd3; cyc();
    rd(4, "R6 z hold");
    // R7 MAR
    set_out(6); mar_in_i = 1; #1 chk("R7 mar before edge", mem_addr_o, '0); cyc();
    chk("R7 mar after load", mem_addr_o, mdl[6]);
    set_out(5); cyc();
    chk("R7 mar holds", mem_addr_o, mdl[6]);
    // R8 MDR memory side priority, write data gating
    mdr_mem_in_i = 1; mem_rdata_i = 32'h1357_9BDF; set_out(5); mdr_in_i = 1; cyc();
    mdl[1] = 32'h1357_9BDF;
    #1 chk("R8 wdata gated", mem_wdata_o, '0); chk("R8 wr low", {31'b0, mem_wr_o}, 32'd0);
    mdr_mem_out_i = 1; #1 chk("R8 wdata driven", mem_wdata_o, 32'h1357_9BDF);
    chk("R8 wr high", {31'b0, mem_wr_o}, 32'd1); cyc();
    rd(1, "R8 mem priority");
    set_out(6); mdr_in_i = 1; cyc(); mdl[1] = mdl[6];
    rd(1, "R8 bus side load");
    // random operations
    for (int it = 0; it < 300; it++) begin
      int a, b, d;
      logic [2:0] op;
      a = 5 + int'($urandom_range(0, 3)); b = 5 + int'($urandom_range(0, 3));
      d = ($urandom_range(0, 5) == 0) ? 3 : 5 + int'($urandom_range(0, 3));
      op = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 3) == 0) ld(a, $urandom());
      if ($urandom_range(0, 3) == 0) ld(b, $urandom());
      alu3(a, b, d, op, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 4) == 0), "R5 R9 random");
    end
    // R1 asynchronous reset mid-run
    #1 rst_ni = 1'b0; #1;
    chk("R1 async mar clear", mem_addr_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < 9; i++) mdl[i] = '0;
    @(negedge clk_i);
    for (int s = 0; s < 9; s++) rd(s, "R1 after async reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule